// File: doc/BRIEF.md
# Expandable Flag Bus Ownership Controller

Each device in a chain of multi-queue buffer devices places the status of its eight queues on one shared 8-bit flag bus. Every device carries one copy of this controller. The controller decides, clock by clock, whether its device drives that bus. A device that does not own the bus releases every bit. In this model, release means a per-bit output enable held low, which stands in for high impedance. The flags themselves, queue storage and the pads are outside the block.

The ownership scheme is chosen by a strap that is captured while master reset is held. In addressed mode, an external agent names the owning device through the upper bits of the queue address while pulsing a flag strobe. In ring mode, a token travels device to device: one device is strapped as master and starts the ring, and each device's token output feeds the token input of the next. The last device feeds the first.

Top module: `flagbus_owner_ctl`

## Requirements
- R1: When the device owns the bus, bus bit i carries the flag of local queue i+1. Queue 1 maps to bit 0 and queue 8 maps to bit 7.
- R2: The mode strap is captured on every clock edge while reset is low: 0 selects addressed mode and 1 selects ring mode. Changes to the strap after reset have no effect. In ring mode the flag strobe is ignored, and in addressed mode the token input is ignored.
- R3: In addressed mode, a clock edge that sees the flag strobe high and the queue-select strobe low makes the device the owner when address bits [5:3] equal the 3-bit device ID. If those bits differ, the device stops being the owner.
- R4: In addressed mode, the output enables reflect a strobe presented in cycle n from cycle n+1 onward, that is, right after the sampling edge.
- R5: In addressed mode, ownership can change on every consecutive clock cycle.
- R6: If the flag strobe and the queue-select strobe are both high on the same edge, the select is dropped and the current ownership is kept.
- R7: After reset, and at any time the device is not the owner, all 8 output enables are 0, token output is 0 and sync is 0.
- R8: In ring mode, a device strapped as master owns the bus in the first cycle after reset is released, and its sync output is 1 in that cycle only. A device not strapped as master does not own the bus in that cycle.
- R9: In ring mode, after the first cycle, the device owns the bus in cycle n+1 exactly when its token input was 1 in cycle n. Token output is 1 in exactly the cycles in which the device owns the bus.
- R10: The driven bus value is the local flag input registered on every clock edge, so it trails the flag input by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| rst_n | input | 1 | Master reset, active low, synchronous |
| mode_strap_i | input | 1 | Ownership mode strap: 0 addressed, 1 ring |
| master_strap_i | input | 1 | 1 marks the device that starts the ring |
| dev_id_i | input | 3 | Device identity compared with address bits [5:3] |
| qaddr_i | input | 6 | Queue address; upper 3 bits name the device |
| fstrobe_i | input | 1 | Flag-bus select strobe |
| qsel_i | input | 1 | Write queue-select strobe |
| token_i | input | 1 | Ring token from the previous device |
| qflags_i | input | 8 | Local per-queue almost-full flags |
| bus_o | output | 8 | Flag bus data |
| bus_oe_o | output | 8 | Per-bit output enable; 0 models high impedance |
| token_o | output | 1 | Ring token to the next device; high while owning |
| sync_o | output | 1 | Master's one-cycle start pulse |

## Verification
The assertions check on every cycle the following. A matching or a mismatching strobe takes effect after the edge. A colliding strobe leaves the output enables unchanged. A token received in ring mode becomes ownership on the next cycle. Sync only appears together with the token. The driven data equals the previous cycle's flags. Only the bench scenarios can show the cycle-by-cycle story. This covers the mode being fixed at reset even when the strap flips afterward, the master's single start cycle versus a non-master's silence, a self-looped single-device ring keeping ownership without a second sync, and the queue-to-bit mapping.

// File: rtl/fbo_pkg.sv
package fbo_pkg;

    typedef enum logic {
        MODE_ADDRESSED = 1'b0,
        MODE_RING      = 1'b1
    } own_mode_e;

    typedef struct packed {
        own_mode_e mode;
        logic      started;
        logic      owner;
        logic      sync;
    } own_state_t;

endpackage

// File: rtl/fbo_addr_match.sv
module fbo_addr_match #(
    parameter int ADDR_W = 6,
    parameter int ID_W   = 3
) (
    input  logic [ADDR_W-1:0] qaddr_i,
    input  logic [ID_W-1:0]   dev_id_i,
    input  logic              fstrobe_i,
    input  logic              qsel_i,
    output logic              take_o,
    output logic              hit_o
);
    localparam int TOP = ADDR_W - 1;

    // a select is only honoured when no queue select collides with it
    assign take_o = fstrobe_i & ~qsel_i;
    assign hit_o  = (qaddr_i[TOP -: ID_W] == dev_id_i);

endmodule

// File: rtl/fbo_ring_step.sv
module fbo_ring_step (
    input  logic started_i,
    input  logic master_i,
    input  logic token_i,
    output logic own_next_o,
    output logic sync_next_o
);
    always_comb begin
        if (!started_i) begin
            own_next_o  = master_i;
            sync_next_o = master_i;
        end else begin
            own_next_o  = token_i;
            sync_next_o = 1'b0;
        end
    end

endmodule

// File: rtl/fbo_drive_stage.sv
module fbo_drive_stage #(
    parameter int BUS_W = 8
) (
    input  logic             owner_i,
    input  logic [BUS_W-1:0] flags_i,
    output logic [BUS_W-1:0] bus_o,
    output logic [BUS_W-1:0] bus_oe_o
);
    for (genvar b = 0; b < BUS_W; b++) begin : g_lane
        assign bus_oe_o[b] = owner_i;
        assign bus_o[b]    = owner_i ? flags_i[b] : 1'b0;
    end

endmodule

// File: rtl/flagbus_owner_ctl.sv
module flagbus_owner_ctl
    import fbo_pkg::*;
#(
    parameter int BUS_W  = 8,
    parameter int ADDR_W = 6,
    parameter int ID_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_strap_i,
    input  logic              master_strap_i,
    input  logic [ID_W-1:0]   dev_id_i,
    input  logic [ADDR_W-1:0] qaddr_i,
    input  logic              fstrobe_i,
    input  logic              qsel_i,
    input  logic              token_i,
    input  logic [BUS_W-1:0]  qflags_i,
    output logic [BUS_W-1:0]  bus_o,
    output logic [BUS_W-1:0]  bus_oe_o,
    output logic              token_o,
    output logic              sync_o
);
    localparam int TOP = ADDR_W - 1;

    own_state_t       st_d, st_q;
    logic [BUS_W-1:0] flags_d, flags_q;
    logic             sel_take, sel_hit;
    logic             ring_own, ring_sync;

    fbo_addr_match #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_match (
        .qaddr_i   (qaddr_i),
        .dev_id_i  (dev_id_i),
        .fstrobe_i (fstrobe_i),
        .qsel_i    (qsel_i),
        .take_o    (sel_take),
        .hit_o     (sel_hit)
    );

    fbo_ring_step u_ring (
        .started_i   (st_q.started),
        .master_i    (master_strap_i),
        .token_i     (token_i),
        .own_next_o  (ring_own),
        .sync_next_o (ring_sync)
    );

    always_comb begin
        st_d         = st_q;
        flags_d      = qflags_i;
        st_d.started = 1'b1;
        st_d.sync    = 1'b0;
        if (st_q.mode == MODE_RING) begin
            st_d.owner = ring_own;
            st_d.sync  = ring_sync;
        end else if (sel_take) begin
            st_d.owner = sel_hit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode    <= own_mode_e'(mode_strap_i);
            st_q.started <= 1'b0;
            st_q.owner   <= 1'b0;
            st_q.sync    <= 1'b0;
            flags_q      <= '0;
        end else begin
            st_q    <= st_d;
            flags_q <= flags_d;
        end
    end

    fbo_drive_stage #(.BUS_W(BUS_W)) u_drive (
        .owner_i  (st_q.owner),
        .flags_i  (flags_q),
        .bus_o    (bus_o),
        .bus_oe_o (bus_oe_o)
    );

    assign token_o = (st_q.mode == MODE_RING) & st_q.owner;
    assign sync_o  = st_q.sync;

    // R3: matching select gives ownership on the next cycle
    p_addr_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_ADDRESSED && fstrobe_i && !qsel_i
         && qaddr_i[TOP -: ID_W] == dev_id_i) |=> bus_oe_o[0]);

    // R3: a select naming another device drops ownership
    p_addr_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_ADDRESSED && fstrobe_i && !qsel_i
         && qaddr_i[TOP -: ID_W] != dev_id_i) |=> bus_oe_o == '0);

    // R6: colliding strobes keep the present ownership
    p_collide_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_ADDRESSED && fstrobe_i && qsel_i)
        |=> $stable(bus_oe_o));

    // R9: token received becomes ownership next cycle
    p_ring_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_RING && st_q.started && token_i) |=> token_o);

    // R8: the start pulse only accompanies a held token
    p_sync_owned_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sync_o |-> token_o);

    // R10: driven data trails the local flags by one edge
    p_data_lag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe_o[0] |-> bus_o == $past(qflags_i));

endmodule

// File: tb/tb_flagbus_owner_ctl.sv
module tb_flagbus_owner_ctl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_strap = 1'b0;
    logic       master_strap = 1'b0;
    logic [2:0] dev_id = 3'd5;
    logic [5:0] qaddr = '0;
    logic       fstrobe = 1'b0;
    logic       qsel = 1'b0;
    logic       tok_drv = 1'b0;
    logic       loop_en = 1'b0;
    logic [7:0] qflags = '0;
    logic [7:0] bus, bus_oe;
    logic       tok_out, sync;
    logic       tok_in;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    assign tok_in = loop_en ? tok_out : tok_drv;

    always #4 clk = ~clk;

    flagbus_owner_ctl dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .mode_strap_i   (mode_strap),
        .master_strap_i (master_strap),
        .dev_id_i       (dev_id),
        .qaddr_i        (qaddr),
        .fstrobe_i      (fstrobe),
        .qsel_i         (qsel),
        .token_i        (tok_in),
        .qflags_i       (qflags),
        .bus_o          (bus),
        .bus_oe_o       (bus_oe),
        .token_o        (tok_out),
        .sync_o         (sync)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic m, input logic mst);
        rst_n        = 1'b0;
        mode_strap   = m;
        master_strap = mst;
        fstrobe      = 1'b0;
        qsel         = 1'b0;
        tok_drv      = 1'b0;
        loop_en      = 1'b0;
        step();
        step();
        rst_n = 1'b1;
    endtask

    task automatic t_reset_addressed();
        do_reset(1'b0, 1'b0);
        chk("R7 oe after reset", bus_oe, 8'h00);
        chk("R7 token/sync after reset", {6'd0, tok_out, sync}, 8'h00);
        mode_strap   = 1'b1;
        master_strap = 1'b1;
        step();
        chk("R2 strap change after reset ignored", bus_oe, 8'h00);
        tok_drv = 1'b1;
        step();
        chk("R2 token ignored in addressed mode", bus_oe, 8'h00);
        tok_drv = 1'b0;
    endtask

    task automatic t_addr_select();
        qflags  = 8'hA5;
        qaddr   = {3'd5, 3'd2};
        fstrobe = 1'b1;
        chk("R4 not yet owner before edge", bus_oe, 8'h00);
        step();
        fstrobe = 1'b0;
        chk("R3 R4 owner after match", bus_oe, 8'hFF);
        chk("R10 data after select", bus, 8'hA5);
        qflags = 8'h01;
        step();
        chk("R1 queue1 on bit0", bus, 8'h01);
        qflags = 8'h80;
        step();
        chk("R1 queue8 on bit7", bus, 8'h80);
        qflags = 8'h3C;
        chk("R10 data lags one edge", bus, 8'h80);
        step();
        chk("R10 data updated", bus, 8'h3C);
    endtask

    task automatic t_consecutive();
        fstrobe = 1'b1;
        qaddr   = {3'd2, 3'd7};
        step();
        chk("R3 R5 mismatch releases", bus_oe, 8'h00);
        chk("R7 non-owner data quiet", bus & bus_oe, 8'h00);
        qaddr = {3'd5, 3'd0};
        step();
        chk("R5 match next cycle", bus_oe, 8'hFF);
        qaddr = {3'd4, 3'd5};
        step();
        chk("R5 mismatch next cycle", bus_oe, 8'h00);
        fstrobe = 1'b0;
    endtask

    task automatic t_collision();
        fstrobe = 1'b1;
        qsel    = 1'b1;
        qaddr   = {3'd5, 3'd1};
        step();
        chk("R6 collide keeps non-owner", bus_oe, 8'h00);
        qsel = 1'b0;
        step();
        chk("R3 owner after clean match", bus_oe, 8'hFF);
        qsel  = 1'b1;
        qaddr = {3'd0, 3'd1};
        step();
        chk("R6 collide keeps owner", bus_oe, 8'hFF);
        fstrobe = 1'b0;
        qsel    = 1'b0;
    endtask

    task automatic t_ring_master();
        do_reset(1'b1, 1'b1);
        chk("R7 ring oe before release", bus_oe, 8'h00);
        step();
        chk("R8 master owns first cycle", bus_oe, 8'hFF);
        chk("R8 R9 sync and token first cycle", {6'd0, tok_out, sync}, 8'h03);
        fstrobe = 1'b1;
        qaddr   = {3'd5, 3'd0};
        step();
        chk("R9 releases without token", bus_oe, 8'h00);
        chk("R8 sync gone", {7'd0, sync}, 8'h00);
        step();
        chk("R2 strobe ignored in ring mode", bus_oe, 8'h00);
        fstrobe = 1'b0;
    endtask

    task automatic t_ring_member();
        do_reset(1'b1, 1'b0);
        step();
        chk("R8 non-master idle first cycle", {bus_oe[0], 6'd0, sync}, 8'h00);
        tok_drv = 1'b1;
        step();
        tok_drv = 1'b0;
        chk("R9 token makes owner", {bus_oe[0], 6'd0, tok_out}, 8'h81);
        step();
        chk("R9 token passed on", {7'd0, tok_out}, 8'h00);
    endtask

    task automatic t_ring_loop();
        do_reset(1'b1, 1'b1);
        loop_en = 1'b1;
        step();
        chk("R8 loop first sync", {7'd0, sync}, 8'h01);
        step();
        step();
        chk("R9 single-device loop keeps bus", bus_oe, 8'hFF);
        chk("R8 no second sync", {7'd0, sync}, 8'h00);
        loop_en = 1'b0;
    endtask

    initial begin
        t_reset_addressed();
        t_addr_select();
        t_consecutive();
        t_collision();
        t_ring_master();
        t_ring_member();
        t_ring_loop();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule